// File: doc/BRIEF.md
# Integer butterfly multiply rounding unit

This datapath evaluates one complete DCT butterfly pair per operation. From two signed operands `a` and `b`, a signed coefficient `c` and a shift amount `n`, it forms both the sum `a + b` and the difference `a - b`. Each is multiplied by `c` at full double width. Each product is then rounded by a power of two: `2^(n-1)` is added and the result is shifted right arithmetically by `n`. Each result is cut back to XLEN bits.

The sum result goes to the primary destination, `out_rt`. The difference result goes to the companion destination, `out_rs`. A two-coefficient butterfly `a*c1 ± b*c2` is built by issuing the operation twice, with the operands swapped and a different coefficient, and accumulating the results outside the block. The typical video-transform setting is `n = 14`.

The unit is a two-stage pipeline with a valid/ready handshake on both sides. Stage one forms the widened sum and difference. Stage two holds two parallel multiply-round lanes and the output register. It accepts one operation per cycle while the output is being drained.

Top module: `bfly_round_unit`

## Requirements
- R1: The sum `a + b` and the difference `a - b` are formed at XLEN+1 bits, so that no input pair wraps: for example, `MIN + MIN` gives `-2^XLEN`.
- R2: Each of the sum and the difference is multiplied as a signed value by the signed coefficient `c`, at 2*XLEN+2 bits, with no intermediate overflow.
- R3: For `1 <= n <= 31`, each product has `2^(n-1)` added and is then shifted right arithmetically by `n`, with the sign extended. A tie rounds toward plus infinity.
- R4: For `n = 0`, no rounding constant is added and the product is passed through unshifted.
- R5: Each result is the low XLEN bits of the rounded value, with no saturation.
- R6: `out_rt` carries the result of the sum lane and `out_rs` carries the result of the difference lane.
- R7: An operation accepted at a rising edge, when `in_valid` and `in_ready` are both high, appears on `out_valid` two rising edges later if the output is not stalled. Back-to-back operations are accepted on consecutive cycles.
- R8: While `out_valid` is high and `out_ready` is low, `out_rt` and `out_rs` hold their values. Once both stages are full and stalled, `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R9: While `rst_n` is low and after its release, `out_valid` is low and `in_ready` is high.
- R10: `in_sh` is a 5-bit unsigned shift amount, and every value from 0 to 31 is honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Unit can take the operand set this cycle |
| in_a | input | XLEN | Signed operand a (destination-register operand) |
| in_b | input | XLEN | Signed operand b (first source operand) |
| in_c | input | XLEN | Signed coefficient (second source operand) |
| in_sh | input | SHW | Unsigned shift amount n |
| out_valid | output | 1 | Result pair is presented |
| out_ready | input | 1 | Consumer takes the result pair this cycle |
| out_rt | output | XLEN | Rounded result of (a+b)*c |
| out_rs | output | XLEN | Rounded result of (a-b)*c |

## Verification
The arithmetic assertions assume that operand values are known, two-valued integers whenever they reach the lanes. The stimulus drives only defined values, including the most negative value, -1, 0 and the most positive value. The handshake assertions assume that the consumer keeps `out_ready` steady between a falling edge and the following rising edge. The bench changes `out_ready` only on falling edges, toggling it at random in some phases to exercise stalls. It also holds `in_sh` within the 5-bit range, covering 0, 1, 14 and 31.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  typedef enum logic {
    LANE_SUM  = 1'b0,
    LANE_DIFF = 1'b1
  } lane_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic signed [XLEN-1:0] a,
  input  logic signed [XLEN-1:0] b,
  output logic signed [XLEN:0]   sum,
  output logic signed [XLEN:0]   diff
);
  localparam int unsigned WW = XLEN + 1;

  function automatic logic signed [WW-1:0] wide_add(input logic signed [XLEN-1:0] x,
                                                    input logic signed [XLEN-1:0] y);
    return WW'(x) + WW'(y);
  endfunction

  function automatic logic signed [WW-1:0] wide_sub(input logic signed [XLEN-1:0] x,
                                                    input logic signed [XLEN-1:0] y);
    return WW'(x) - WW'(y);
  endfunction

  assign sum  = wide_add(a, b);
  assign diff = wide_sub(a, b);

  // sum + diff must equal 2a exactly when no wrap happened
  always_comb begin
    AST_BFLY_IDENTITY: assert ((WW+1)'(sum) + (WW+1)'(diff) == ((WW+1)'(a) <<< 1)); // R1
  end
endmodule

// File: rtl/bfly_lane.sv
module bfly_lane #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SHW  = 5
) (
  input  logic signed [XLEN:0]   op,
  input  logic signed [XLEN-1:0] coef,
  input  logic [SHW-1:0]         sh,
  output logic signed [XLEN-1:0] res
);
  localparam int unsigned PW = 2 * XLEN + 2;

  logic signed [PW-1:0] prod_w;
  logic                 zero_in_w;

  function automatic logic signed [PW-1:0] mul_wide(input logic signed [XLEN:0]   x,
                                                    input logic signed [XLEN-1:0] y);
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ye;
    xe = PW'(x);
    ye = PW'(y);
    return xe * ye;
  endfunction

  function automatic logic signed [XLEN-1:0] round_shift(input logic signed [PW-1:0] p,
                                                         input logic [SHW-1:0]     n);
    logic signed [PW-1:0] bias;
    if (n == '0) bias = '0;
    else         bias = PW'(1) << (n - 1'b1);
    return XLEN'((p + bias) >>> n);
  endfunction

  assign prod_w    = mul_wide(op, coef);
  assign zero_in_w = (op == '0) || (coef == '0);
  assign res       = round_shift(prod_w, sh);

  always_comb begin
    if (!zero_in_w) begin
      AST_PROD_SIGN: assert (prod_w[PW-1] == (op[XLEN] ^ coef[XLEN-1])); // R2
    end
    if (zero_in_w) begin
      AST_PROD_ZERO: assert (prod_w == '0); // R2
    end
    if (sh == '0) begin
      AST_PASS_THROUGH: assert (res == prod_w[XLEN-1:0]); // R4
    end
  end
endmodule

// File: rtl/bfly_round_unit.sv
module bfly_round_unit
  import bfly_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SHW  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [XLEN-1:0] in_a,
  input  logic signed [XLEN-1:0] in_b,
  input  logic signed [XLEN-1:0] in_c,
  input  logic [SHW-1:0]         in_sh,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [XLEN-1:0] out_rt,
  output logic signed [XLEN-1:0] out_rs
);
  logic signed [XLEN:0]   as_sum, as_diff;
  logic                   s1_v;
  logic signed [XLEN:0]   s1_sum, s1_diff;
  logic signed [XLEN-1:0] s1_c;
  logic [SHW-1:0]         s1_sh;
  logic                   s1_en, s2_en;
  logic signed [XLEN-1:0] lane_res [NUM_LANES];

  assign s2_en    = !out_valid || out_ready;
  assign s1_en    = !s1_v || s2_en;
  assign in_ready = s1_en;

  bfly_addsub #(.XLEN(XLEN)) u_addsub (
    .a(in_a), .b(in_b), .sum(as_sum), .diff(as_diff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_sum  <= '0;
      s1_diff <= '0;
      s1_c    <= '0;
      s1_sh   <= '0;
    end else if (s1_en) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_sum  <= as_sum;
        s1_diff <= as_diff;
        s1_c    <= in_c;
        s1_sh   <= in_sh;
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic signed [XLEN:0] lane_op;
    assign lane_op = (lane_e'(g) == LANE_SUM) ? s1_sum : s1_diff;
    bfly_lane #(.XLEN(XLEN), .SHW(SHW)) u_lane (
      .op(lane_op), .coef(s1_c), .sh(s1_sh), .res(lane_res[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rt    <= '0;
      out_rs    <= '0;
    end else if (s2_en) begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_rt <= lane_res[LANE_SUM];
        out_rs <= lane_res[LANE_DIFF];
      end
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rt) && $stable(out_rs)); // R8
  AST_READY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
  AST_S1_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && (!out_valid || out_ready) |=> out_valid); // R7
  AST_EMPTY_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_v && (!out_valid || out_ready) |=> !out_valid); // R7
endmodule

// File: tb/bfly_round_unit_bench.sv
`timescale 1ns/1ps
module bfly_round_unit_bench;
  localparam int XLEN = 32;
  localparam int SHW  = 5;
  localparam logic signed [XLEN-1:0] VMIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic signed [XLEN-1:0] VMAX = {1'b0, {(XLEN-1){1'b1}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [XLEN-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic [SHW-1:0] in_sh = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [XLEN-1:0] out_rt, out_rs;

  int checks = 0;
  int errors = 0;
  bit rand_ready = 1'b0;
  bit fixed_ready = 1'b1;
  logic [2*XLEN-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  bfly_round_unit #(.XLEN(XLEN), .SHW(SHW)) u_bfly_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_sh(in_sh),
    .out_valid(out_valid), .out_ready(out_ready), .out_rt(out_rt), .out_rs(out_rs)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: wide integer maths, floor division by 2^n after adding half
  function automatic logic [XLEN-1:0] ref_val(input logic signed [XLEN-1:0] a,
                                              input logic signed [XLEN-1:0] b,
                                              input logic signed [XLEN-1:0] c,
                                              input int n, input bit use_diff);
    logic signed [127:0] s, p, q, d;
    s = use_diff ? (128'(a) - 128'(b)) : (128'(a) + 128'(b));
    p = s * 128'(c);
    if (n == 0) return p[XLEN-1:0];
    p = p + (128'sd1 <<< (n - 1));
    d = 128'sd1 <<< n;
    q = p / d;
    if ((p % d != 0) && p < 0) q = q - 1;
    return q[XLEN-1:0];
  endfunction

  always @(negedge clk) out_ready <= rand_ready ? ($urandom % 4 != 0) : fixed_ready;

  // monitor: pops expected pairs as results leave
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected output", 32'h1, 32'h0);
        end else begin
          logic [2*XLEN-1:0] e;
          e = exp_q.pop_front();
          check("R6 out_rt sum lane (R1 R2 R3 R5)", out_rt, e[2*XLEN-1:XLEN]);
          check("R6 out_rs diff lane (R1 R2 R3 R5)", out_rs, e[XLEN-1:0]);
        end
      end
    end
  end

  task automatic send(input logic signed [XLEN-1:0] a, input logic signed [XLEN-1:0] b,
                      input logic signed [XLEN-1:0] c, input int n);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_sh = SHW'(n);
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back({ref_val(a, b, c, n, 1'b0), ref_val(a, b, c, n, 1'b1)});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || out_valid) && guard < 1000) begin
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    logic signed [XLEN-1:0] corners [5];
    int shifts [4];
    logic [XLEN-1:0] held_rt, held_rs;
    corners[0] = VMIN; corners[1] = -1; corners[2] = 0; corners[3] = VMAX; corners[4] = 1;
    shifts[0] = 0; shifts[1] = 1; shifts[2] = 14; shifts[3] = 31;

    repeat (3) @(negedge clk);
    #1;
    check("R9 out_valid in reset", 32'(out_valid), 32'h0);
    check("R9 in_ready in reset", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R9 out_valid after reset", 32'(out_valid), 32'h0);

    // latency: accept, one edge in stage one, second edge at output
    send(32'sd1000, 32'sd24, 32'sd11585, 14);
    #1;
    check("R7 not valid after one edge", 32'(out_valid), 32'h0);
    @(negedge clk); #1;
    check("R7 valid after two edges", 32'(out_valid), 32'h1);
    drain();

    // directed rounding points: tie rounds up, negative tie
    send(32'sd1, 32'sd0, 32'sd1, 1);   // 1/2 -> 1 (R3)
    send(-32'sd1, 32'sd0, 32'sd1, 1);  // -1/2 -> 0 (R3)
    send(-32'sd3, 32'sd0, 32'sd1, 1);  // -3/2 -> -1 (R3)
    send(VMIN, VMIN, VMIN, 0);         // wrap of full product, R4 R5
    send(VMAX, VMAX, VMAX, 31);        // R10 max shift
    drain();

    // corner grid, back to back
    for (int ia = 0; ia < 5; ia++)
      for (int ib = 0; ib < 5; ib++)
        for (int ic = 0; ic < 5; ic++)
          for (int is = 0; is < 4; is++)
            send(corners[ia], corners[ib], corners[ic], shifts[is]);
    drain();

    // stall: fill both stages with out_ready low
    fixed_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    send(32'sd7, 32'sd3, -32'sd5, 2);
    send(32'sd9, -32'sd4, 32'sd6, 3);
    #1;
    check("R8 in_ready low when full", 32'(in_ready), 32'h0);
    check("R8 out_valid while stalled", 32'(out_valid), 32'h1);
    held_rt = out_rt; held_rs = out_rs;
    repeat (3) @(negedge clk);
    #1;
    check("R8 out_rt held", out_rt, held_rt);
    check("R8 out_rs held", out_rs, held_rs);
    fixed_ready = 1'b1;
    drain();

    // random with random backpressure
    rand_ready = 1'b1;
    for (int k = 0; k < 400; k++)
      send($urandom, $urandom, $urandom, int'($urandom % 32));
    for (int k = 0; k < 100; k++)
      send(32'($urandom % 65536) - 32'sd32768, 32'($urandom % 65536) - 32'sd32768,
           32'($urandom % 32768), 14);
    rand_ready = 1'b0;
    drain();
    check("R7 all results delivered", 32'(exp_q.size()), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule